// File: doc/BRIEF.md
# Mixed-Latency ALU Execute Stage

This block is the arithmetic and logic execute stage of a small 18-bit-instruction processor. Each cycle it may accept one instruction word together with two register values already read from the register file: the value of the destination register and the value of the source register. It decodes the operation and picks the second operand. That operand is either an 8-bit immediate carried in the instruction word or the source register value. The block then returns a 16-bit result with a write-back strobe and keeps a four-bit condition-flag register.

Most operations complete one clock edge after issue. The two shifts and the multiply need a second edge. While one of them is in flight the block raises `busy`, and it ignores any issue presented during that cycle. A memory-load operation is not executed here. It only produces a one-cycle `mem_load` pulse for the load/store path. Reserved operation codes produce a one-cycle `illegal_op` pulse.

Top module: `mixlat_alu`

## Requirements
- R1: An issued word whose bits 17:16 are 00 uses bits 7:0 zero-extended to 16 bits as the second operand. A word with 10 in bits 17:16 uses `src_val`. Bits 15:12 are the operation code in both cases. A word with 01 or 11 in bits 17:16 writes nothing, raises no pulse and leaves the flags unchanged.
- R2: The single-cycle operations are 0100 AND, 0101 OR, 0110 XOR (each applied to `dst_val` and the operand), 1000 invert of the operand, 1010 move of the operand and 1011 byte swap of the operand. For each of these, `result` and `wr_en` appear one clock edge after issue and last one cycle.
- R3: Code 1100 returns `dst_val` plus the operand, with C set to the carry out. Code 1110 returns `dst_val` minus the operand, with C set to the borrow (unsigned `dst_val` less than the operand). For both, V is set on signed two's-complement overflow.
- R4: Code 1111 (compare) sets the flags exactly as 1110 would and does not assert `wr_en`.
- R5: `flags` is {Z,C,N,V} in bits 3..0. Every writing operation and compare sets Z when the result is zero and sets N to result bit 15. All operations other than add, subtract and compare clear V and keep C.
- R6: Code 0000 shifts `dst_val` right logically by operand bits 3:0. Code 0001 shifts it left by the same amount. Code 0010 returns the low 16 bits of `dst_val` times the operand. For these three, `busy` is high for exactly the one cycle after issue, and `result` with `wr_en` follow one edge later.
- R7: An issue presented while `busy` is high is ignored. It gives no write, no pulse and no flag change.
- R8: Code 1001 (load) pulses `mem_load` for one cycle after issue, with no write and no flag change.
- R9: The reserved codes 0011, 0111 and 1101 pulse `illegal_op` for one cycle, with no write and no flag change.
- R10: During and right after reset, `busy`, `wr_en`, `mem_load`, `illegal_op`, `flags` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue | input | 1 | An instruction word is presented this cycle |
| instr | input | 18 | Instruction word |
| dst_val | input | 16 | Value of the destination register (first operand) |
| src_val | input | 16 | Value of the source register (register form operand) |
| busy | output | 1 | A two-cycle operation is in flight |
| result | output | 16 | Result of the most recent writing operation |
| wr_en | output | 1 | Write `result` back this cycle |
| flags | output | 4 | Condition flags {Z,C,N,V} |
| mem_load | output | 1 | One-cycle pulse for a load operation |
| illegal_op | output | 1 | One-cycle pulse for a reserved operation code |

## Verification
Every operation code is swept in both operand forms against operand values sitting at the sign, carry and zero boundaries. A design that sign-extended the immediate, or inverted the sense of the subtract carry, would report wrong results and wrong C. A design that let logic operations touch C, or left V set, shows up in the flag state the bench carries from one operation to the next. Compare and load are checked for absent writes. The bench also issues a move during a shift's busy cycle: a design that accepted that issue would overwrite the shift result or raise a second write.

// File: rtl/mixlat_alu_pkg.sv
package mixlat_alu_pkg;

    typedef enum logic [3:0] {
        OP_LSR  = 4'b0000,
        OP_LSL  = 4'b0001,
        OP_MUL  = 4'b0010,
        OP_RSV3 = 4'b0011,
        OP_AND  = 4'b0100,
        OP_OR   = 4'b0101,
        OP_XOR  = 4'b0110,
        OP_RSV7 = 4'b0111,
        OP_INV  = 4'b1000,
        OP_LOAD = 4'b1001,
        OP_MOV  = 4'b1010,
        OP_SWAP = 4'b1011,
        OP_ADD  = 4'b1100,
        OP_RSVD = 4'b1101,
        OP_SUB  = 4'b1110,
        OP_CMP  = 4'b1111
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_FAST,
        CLS_SLOW,
        CLS_LOAD,
        CLS_BAD
    } op_class_e;

    typedef struct packed {
        logic z;
        logic c;
        logic n;
        logic v;
    } cc_t;

endpackage

// File: rtl/mixlat_alu_decode.sv
module mixlat_alu_decode
    import mixlat_alu_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned IMM_W   = 8,
    parameter int unsigned INSTR_W = 18
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  src_val,
    output logic               form_ok,
    output alu_op_e            op,
    output op_class_e          op_class,
    output logic [DATA_W-1:0]  operand
);
    localparam int unsigned PFX_HI = INSTR_W - 1;
    localparam int unsigned PFX_LO = INSTR_W - 2;
    localparam int unsigned OP_HI  = INSTR_W - 3;
    localparam int unsigned OP_LO  = INSTR_W - 6;

    logic unused_dst_field;
    assign unused_dst_field = ^instr[OP_LO-1:IMM_W];

    always_comb begin
        form_ok = (instr[PFX_LO] == 1'b0);
        op      = alu_op_e'(instr[OP_HI:OP_LO]);
        if (instr[PFX_HI]) begin
            operand = src_val;
        end else begin
            operand = {{(DATA_W-IMM_W){1'b0}}, instr[IMM_W-1:0]};
        end
        case (op)
            OP_LSR, OP_LSL, OP_MUL:    op_class = CLS_SLOW;
            OP_LOAD:                   op_class = CLS_LOAD;
            OP_RSV3, OP_RSV7, OP_RSVD: op_class = CLS_BAD;
            default:                   op_class = CLS_FAST;
        endcase
    end
endmodule

// File: rtl/mixlat_alu_fast.sv
module mixlat_alu_fast
    import mixlat_alu_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  cc_t               cc_in,
    output logic [DATA_W-1:0] res,
    output logic              wr,
    output cc_t               cc_out
);
    localparam int unsigned MSB  = DATA_W - 1;
    localparam int unsigned HALF = DATA_W / 2;

    logic [DATA_W:0] sum_ext;
    logic [DATA_W:0] dif_ext;

    always_comb begin
        sum_ext = {1'b0, a} + {1'b0, b};
        dif_ext = {1'b0, a} + {1'b0, ~b} + {{DATA_W{1'b0}}, 1'b1};
        res     = '0;
        wr      = 1'b1;
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_INV:  res = ~b;
            OP_MOV:  res = b;
            OP_SWAP: res = {b[HALF-1:0], b[DATA_W-1:HALF]};
            OP_ADD:  res = sum_ext[DATA_W-1:0];
            OP_SUB:  res = dif_ext[DATA_W-1:0];
            OP_CMP: begin
                res = dif_ext[DATA_W-1:0];
                wr  = 1'b0;
            end
            default: wr = 1'b0;
        endcase

        cc_out.z = (res == '0);
        cc_out.n = res[MSB];
        cc_out.c = cc_in.c;
        cc_out.v = 1'b0;
        case (op)
            OP_ADD: begin
                cc_out.c = sum_ext[DATA_W];
                cc_out.v = (a[MSB] == b[MSB]) && (sum_ext[MSB] != a[MSB]);
            end
            OP_SUB, OP_CMP: begin
                cc_out.c = ~dif_ext[DATA_W];
                cc_out.v = (a[MSB] != b[MSB]) && (dif_ext[MSB] != a[MSB]);
            end
            OP_AND, OP_OR, OP_XOR, OP_INV, OP_MOV, OP_SWAP: ;
            default: cc_out = cc_in;
        endcase
    end
endmodule

// File: rtl/mixlat_alu_slow.sv
module mixlat_alu_slow
    import mixlat_alu_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res
);
    localparam int unsigned SHW = $clog2(DATA_W);

    typedef struct packed {
        alu_op_e           op;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } slow_st_t;

    slow_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.op = op;
            st_d.a  = a;
            st_d.b  = b;
        end
        case (st_q.op)
            OP_LSR:  res = st_q.a >> st_q.b[SHW-1:0];
            OP_LSL:  res = st_q.a << st_q.b[SHW-1:0];
            default: res = st_q.a * st_q.b;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{op: OP_LSR, a: '0, b: '0};
        end else begin
            st_q <= st_d;
        end
    end

    AST_START_IS_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (op == OP_LSR || op == OP_LSL || op == OP_MUL)); // R6
endmodule

// File: rtl/mixlat_alu.sv
module mixlat_alu
    import mixlat_alu_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned IMM_W   = 8,
    parameter int unsigned INSTR_W = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  dst_val,
    input  logic [DATA_W-1:0]  src_val,
    output logic               busy,
    output logic [DATA_W-1:0]  result,
    output logic               wr_en,
    output logic [3:0]         flags,
    output logic               mem_load,
    output logic               illegal_op
);
    localparam int unsigned MSB = DATA_W - 1;

    typedef struct packed {
        logic              busy;
        logic [DATA_W-1:0] res;
        logic              wr;
        cc_t               cc;
        logic              ld;
        logic              ill;
    } top_st_t;

    top_st_t st_d, st_q;

    logic              form_ok;
    alu_op_e           op;
    op_class_e         op_class;
    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] fast_res;
    logic              fast_wr;
    cc_t               fast_cc;
    logic [DATA_W-1:0] slow_res;
    logic              accept;
    logic              slow_start;

    mixlat_alu_decode #(.DATA_W(DATA_W), .IMM_W(IMM_W), .INSTR_W(INSTR_W)) u_decode (
        .instr    (instr),
        .src_val  (src_val),
        .form_ok  (form_ok),
        .op       (op),
        .op_class (op_class),
        .operand  (operand)
    );

    mixlat_alu_fast #(.DATA_W(DATA_W)) u_fast (
        .op     (op),
        .a      (dst_val),
        .b      (operand),
        .cc_in  (st_q.cc),
        .res    (fast_res),
        .wr     (fast_wr),
        .cc_out (fast_cc)
    );

    mixlat_alu_slow #(.DATA_W(DATA_W)) u_slow (
        .clk   (clk),
        .rst_n (rst_n),
        .start (slow_start),
        .op    (op),
        .a     (dst_val),
        .b     (operand),
        .res   (slow_res)
    );

    assign accept     = issue && form_ok && !st_q.busy;
    assign slow_start = accept && (op_class == CLS_SLOW);

    always_comb begin
        st_d      = st_q;
        st_d.busy = 1'b0;
        st_d.wr   = 1'b0;
        st_d.ld   = 1'b0;
        st_d.ill  = 1'b0;
        if (st_q.busy) begin
            st_d.res  = slow_res;
            st_d.wr   = 1'b1;
            st_d.cc.z = (slow_res == '0);
            st_d.cc.n = slow_res[MSB];
            st_d.cc.v = 1'b0;
        end else if (accept) begin
            case (op_class)
                CLS_FAST: begin
                    if (fast_wr) begin
                        st_d.res = fast_res;
                    end
                    st_d.wr = fast_wr;
                    st_d.cc = fast_cc;
                end
                CLS_SLOW: st_d.busy = 1'b1;
                CLS_LOAD: st_d.ld   = 1'b1;
                default:  st_d.ill  = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy       = st_q.busy;
    assign result     = st_q.res;
    assign wr_en      = st_q.wr;
    assign flags      = st_q.cc;
    assign mem_load   = st_q.ld;
    assign illegal_op = st_q.ill;

    AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy); // R6
    AST_BUSY_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> wr_en); // R6
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_en && !mem_load && !illegal_op); // R7
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, mem_load, illegal_op})); // R8
    AST_LOAD_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_load |-> $stable(flags)); // R8
    AST_ILLEGAL_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> $stable(flags)); // R9
endmodule

// File: tb/mixlat_alu_bench.sv
`timescale 1ns/1ps
module mixlat_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [17:0] instr = '0;
    logic [15:0] dst_val = '0;
    logic [15:0] src_val = '0;
    logic        busy;
    logic [15:0] result;
    logic        wr_en;
    logic [3:0]  flags;
    logic        mem_load;
    logic        illegal_op;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [3:0] ef = 4'h0;  // expected {Z,C,N,V}

    always #5 clk = ~clk;

    mixlat_alu u_mixlat_alu (
        .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr),
        .dst_val(dst_val), .src_val(src_val), .busy(busy), .result(result),
        .wr_en(wr_en), .flags(flags), .mem_load(mem_load), .illegal_op(illegal_op)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pick(input int i);
        case (i)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h7FFF;
            3: return 16'h8000;
            4: return 16'hFFFF;
            5: return 16'h1234;
            6: return 16'h00F0;
            default: return 16'hA5C3;
        endcase
    endfunction

    // expected behaviour; tags R2 R3 R4 R5 R6 R8 R9 per operation group
    task automatic run_op(input bit regf, input logic [3:0] op,
                          input logic [15:0] a, input logic [15:0] bv);
        logic [15:0] b;
        logic [15:0] er;
        logic [16:0] s;
        logic [31:0] p;
        bit slow, ewr, eld, eill;
        string rq;
        b    = regf ? bv : {8'h00, bv[7:0]};  // R1
        slow = (op <= 4'd2);
        ewr  = 1'b0; eld = 1'b0; eill = 1'b0; er = 16'h0;
        rq   = "R2";
        case (op)
            4'd0: begin er = a >> b[3:0]; ewr = 1; rq = "R6"; end
            4'd1: begin er = a << b[3:0]; ewr = 1; rq = "R6"; end
            4'd2: begin p = {16'h0, a} * {16'h0, b}; er = p[15:0]; ewr = 1; rq = "R6"; end
            4'd4: begin er = a & b; ewr = 1; end
            4'd5: begin er = a | b; ewr = 1; end
            4'd6: begin er = a ^ b; ewr = 1; end
            4'd8: begin er = ~b; ewr = 1; end
            4'd10: begin er = b; ewr = 1; end
            4'd11: begin er = {b[7:0], b[15:8]}; ewr = 1; end
            4'd12: begin s = {1'b0, a} + {1'b0, b}; er = s[15:0]; ewr = 1; rq = "R3"; end
            4'd14: begin er = a - b; ewr = 1; rq = "R3"; end
            4'd15: begin er = a - b; rq = "R4"; end
            4'd9: begin eld = 1; rq = "R8"; end
            default: begin eill = 1; rq = "R9"; end
        endcase
        if (ewr || op == 4'd15) begin  // R5 flag rules
            ef[3] = (er == 16'h0);
            ef[1] = er[15];
            ef[0] = 1'b0;
            if (op == 4'd12) begin
                ef[2] = s[16];
                ef[0] = (a[15] == b[15]) && (er[15] != a[15]);
            end else if (op == 4'd14 || op == 4'd15) begin
                ef[2] = (a < b);
                ef[0] = (a[15] != b[15]) && (er[15] != a[15]);
            end
        end
        @(negedge clk);
        instr   = {regf ? 2'b10 : 2'b00, op, 4'h3, regf ? {4'h5, 4'h0} : bv[7:0]};
        dst_val = a;
        src_val = regf ? bv : 16'hDEAD;
        issue   = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        if (slow) begin
            chk(busy == 1'b1, "R6", "busy during slow op", busy, 1);
            chk(wr_en == 1'b0, "R6", "wr_en during busy", wr_en, 0);
            @(negedge clk);
        end
        chk(busy == 1'b0, rq, "busy", busy, 0);
        chk(wr_en == ewr, rq, "wr_en", wr_en, ewr);
        if (ewr) chk(result == er, rq, $sformatf("result op=%b regf=%0d", op, regf), result, er);
        chk(mem_load == eld, rq, "mem_load", mem_load, eld);
        chk(illegal_op == eill, rq, "illegal_op", illegal_op, eill);
        chk(flags == ef, (op == 4'd15 || op[3:2] == 2'b11) ? "R3" : "R5",
            $sformatf("flags op=%b", op), flags, ef);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(busy == 0 && wr_en == 0 && mem_load == 0 && illegal_op == 0, "R10", "controls in reset",
            {busy, wr_en, mem_load, illegal_op}, 0);
        chk(flags == 4'h0, "R10", "flags in reset", flags, 0);
        chk(result == 16'h0, "R10", "result in reset", result, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_en == 0 && busy == 0, "R10", "idle after reset", {busy, wr_en}, 0);

        for (int op = 0; op < 16; op++)
            for (int f = 0; f < 2; f++)
                for (int i = 0; i < 8; i++)
                    for (int j = 0; j < 8; j++)
                        run_op(f[0], op[3:0], pick(i), pick(j));

        // R7: issue during busy ignored
        run_op(1'b1, 4'd12, 16'h0001, 16'h0001);  // known flags: all clear
        @(negedge clk);
        instr = {2'b10, 4'b0001, 4'h3, 8'h50}; dst_val = 16'h0003; src_val = 16'h0004; issue = 1;
        @(negedge clk);
        instr = {2'b10, 4'b1010, 4'h3, 8'h50}; src_val = 16'h0000; dst_val = 16'h0000;
        @(negedge clk);
        issue = 0;
        chk(wr_en == 1 && result == 16'h0030, "R7", "slow result kept", result, 16'h0030);
        @(negedge clk);
        chk(wr_en == 0 && busy == 0, "R7", "ignored issue wrote", {busy, wr_en}, 0);
        chk(result == 16'h0030, "R7", "result after ignored move", result, 16'h0030);
        chk(flags == 4'h0, "R7", "flags after ignored move", flags, 0);
        ef = 4'h0;

        // R1: non-ALU prefixes do nothing
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            instr = {k == 0 ? 2'b01 : 2'b11, 4'b1110, 4'h3, 8'hFF}; dst_val = 0; issue = 1;
            @(negedge clk);
            issue = 0;
            chk(wr_en == 0 && mem_load == 0 && illegal_op == 0 && busy == 0, "R1",
                "other prefix acted", {busy, wr_en, mem_load, illegal_op}, 0);
            chk(flags == ef, "R1", "other prefix flags", flags, ef);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule